// File: doc/BRIEF.md
# USB Root-Hub Port Status and Control Register

This block holds the state of one downstream port of a USB 1.1 root hub and presents it as a single 32-bit register. A read returns the port's status bits and a set of sticky change flags. A write uses the same bit positions as commands. Only bits written as 1 act, and several commands act only when the port is in a suitable state. One registered input tracks whether a device is attached. A second input marks the device as non-removable, so that connect status comes up set after reset.

Two internal cycle timers time the port reset and resume sequences. While they run, the `drive_reset_o` and `drive_resume_o` flags tell the line driver what to signal on the bus. When a sequence ends, the block changes state by itself: it clears the in-progress status, enables the port and raises the matching change flag. Power status is kept only as a record. It drives no pin, and the overcurrent indicator always reads 0.

Top module: `usb_port_sts_reg`

## Requirements
- R1: While `rst_ni` is low, the read word and both drive flags are 0. If `nonremovable_i` is 1, bit 0 reads 1 from the first clock edge after reset is released.
- R2: Writing 1 to bit 8 sets power status, and no write clears it. A write of all zeros changes no bit.
- R3: Bit 0 shows `connect_i`, registered one cycle. Any change of that state sets bit 16. A disconnect clears bits 1 and 2, and it also sets bit 17 if the port was enabled.
- R4: Writing 1 to bit 1 sets enable status only while bit 0 reads 1. Writing 1 to bit 0 clears enable status, and this clear wins over a set in the same write.
- R5: Writing 1 to bit 2 while connected sets suspend status. While disconnected, the same write leaves bit 2 at 0 and sets bit 16 instead.
- R6: Writing 1 to bit 3 while bit 2 reads 1 raises `drive_resume_o` for exactly RESUME_CYC cycles, and bit 2 stays 1 for that whole time. The same write while not suspended does nothing.
- R7: When resume ends, bit 2 clears, bit 18 is set and bit 1 is set.
- R8: Writing 1 to bit 4 raises `drive_reset_o` and bit 4 for exactly RESET_CYC cycles. A further reset write during that time is ignored, and a reset write cancels a resume that is in progress.
- R9: When reset ends, bit 4 clears, bit 20 is set, bit 1 is set and bit 2 is cleared.
- R10: Writing 1 to a change flag in bits 16..20 clears it. A hardware set of the same flag in the same cycle wins over the clear. Bits 3 and 19 and all other unlisted bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write command word |
| rd_data_o | output | 32 | Read status word |
| connect_i | input | 1 | Device attached |
| nonremovable_i | input | 1 | Port carries a fixed device |
| drive_reset_o | output | 1 | Line driver should signal bus reset |
| drive_resume_o | output | 1 | Line driver should signal resume |

## Verification
The property that links the end of reset to the reset-change flag assumes that `connect_i` does not fall in the same cycle that a sequence ends. The stimulus only moves `connect_i` while both timers are idle. The properties on the enable and suspend commands also assume a write is not issued while a timer is finishing. To respect this, the bench waits for each drive flag to drop before it writes again. The timer lengths are made short in the bench, so that the exact duration of each sequence can be counted cycle by cycle.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  localparam int unsigned B_CCS  = 0;
  localparam int unsigned B_PES  = 1;
  localparam int unsigned B_PSS  = 2;
  localparam int unsigned B_OCI  = 3;
  localparam int unsigned B_PRS  = 4;
  localparam int unsigned B_PPS  = 8;
  localparam int unsigned B_CHG0 = 16;
  localparam int unsigned CHG_N  = 5;
  // change flag order within the upper field
  localparam int unsigned C_CONN = 0;
  localparam int unsigned C_EN   = 1;
  localparam int unsigned C_SUSP = 2;
  localparam int unsigned C_OC   = 3;
  localparam int unsigned C_RST  = 4;
endpackage

// File: rtl/port_seq_timer.sv
module port_seq_timer #(
  parameter int unsigned CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYC - 1);
    end
  end
endmodule

// File: rtl/port_chg_flags.sv
module port_chg_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;  // set wins
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_port_sts_reg.sv
module usb_port_sts_reg
  import usb_port_pkg::*;
#(
  parameter int unsigned RESET_CYC  = 480000,  // 10 ms at 48 MHz
  parameter int unsigned RESUME_CYC = 960000   // 20 ms at 48 MHz
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        connect_i,
  input  logic        nonremovable_i,
  output logic        drive_reset_o,
  output logic        drive_resume_o
);
  logic ccs_q, pes_q, pss_q, pps_q;
  logic ccs_d, disc;
  logic rst_busy, rst_done, rst_start;
  logic rsm_busy, rsm_done, rsm_start, rsm_abort;
  logic [CHG_N-1:0] chg_set, chg_clr, chg_q;
  logic [31:0] wd;
  logic unused_wr_bits;

  assign wd = wr_en_i ? wr_data_i : '0;
  assign unused_wr_bits = ^{wr_data_i[31:21], wr_data_i[15:9], wr_data_i[7:5]};

  assign ccs_d = connect_i | nonremovable_i;
  assign disc  = ccs_q & ~ccs_d;

  assign rst_start = wd[B_PRS] & ~rst_busy;
  assign rsm_start = wd[B_OCI] & pss_q & ~rst_busy;
  assign rsm_abort = rst_start | disc;

  port_seq_timer #(.CYC(RESET_CYC)) u_rst_tmr (
    .clk_i, .rst_ni, .start_i(rst_start), .abort_i(1'b0),
    .busy_o(rst_busy), .done_o(rst_done)
  );

  port_seq_timer #(.CYC(RESUME_CYC)) u_rsm_tmr (
    .clk_i, .rst_ni, .start_i(rsm_start), .abort_i(rsm_abort),
    .busy_o(rsm_busy), .done_o(rsm_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_q <= 1'b0;
      pes_q <= 1'b0;
      pss_q <= 1'b0;
      pps_q <= 1'b0;
    end else begin
      ccs_q <= ccs_d;
      if (wd[B_PPS]) pps_q <= 1'b1;

      if (disc)                      pes_q <= 1'b0;
      else if (rst_done || rsm_done) pes_q <= 1'b1;
      else if (wd[B_CCS])            pes_q <= 1'b0;  // clear beats set
      else if (wd[B_PES] && ccs_q)   pes_q <= 1'b1;

      if (disc || rst_done || rsm_done) pss_q <= 1'b0;
      else if (wd[B_PSS] && ccs_q)      pss_q <= 1'b1;
    end
  end

  always_comb begin
    chg_set         = '0;
    chg_set[C_CONN] = (ccs_q ^ ccs_d) | (wd[B_PSS] & ~ccs_q);
    chg_set[C_EN]   = disc & pes_q;
    chg_set[C_SUSP] = rsm_done;
    chg_set[C_OC]   = 1'b0;
    chg_set[C_RST]  = rst_done;
  end
  assign chg_clr = wd[B_CHG0 +: CHG_N];

  port_chg_flags #(.N(CHG_N)) u_chg (
    .clk_i, .rst_ni, .set_i(chg_set), .clr_i(chg_clr), .flag_o(chg_q)
  );

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[B_CCS]             = ccs_q;
    rd_data_o[B_PES]             = pes_q;
    rd_data_o[B_PSS]             = pss_q;
    rd_data_o[B_PRS]             = rst_busy;
    rd_data_o[B_PPS]             = pps_q;
    rd_data_o[B_CHG0 +: CHG_N]   = chg_q;
  end

  assign drive_reset_o  = rst_busy;
  assign drive_resume_o = rsm_busy;
endmodule

// File: rtl/usb_port_sts_chk.sv
module usb_port_sts_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        drive_reset_o,
  input logic        drive_resume_o
);
  assert_power_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[8] |=> rd_data_o[8]);

  assert_enable_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1] && !rd_data_o[0] && !rd_data_o[1]
     && !drive_reset_o && !drive_resume_o) |=> !rd_data_o[1]);

  assert_enable_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && !drive_reset_o && !drive_resume_o) |=> !rd_data_o[1]);

  assert_suspend_unplugged_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[2] && !rd_data_o[0]) |=> rd_data_o[16]);

  assert_resume_in_suspend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_resume_o |-> rd_data_o[2]);

  assert_reset_end_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_reset_o) |-> (rd_data_o[20] && rd_data_o[1] && !rd_data_o[4]));
endmodule

bind usb_port_sts_reg usb_port_sts_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .drive_reset_o(drive_reset_o), .drive_resume_o(drive_resume_o)
);

// File: tb/sim_usb_port_sts_reg.sv
module sim_usb_port_sts_reg;
  localparam int unsigned RST_N = 8;
  localparam int unsigned RSM_N = 12;
  localparam int NV = 16;
  // per row: write word, connect level, expected read word afterwards
  localparam logic [31:0] TW [NV] = '{
    32'h100, 32'h002, 32'h004, 32'h10000, 32'h0, 32'h10000, 32'h0, 32'h002,
    32'h008, 32'h001, 32'h003, 32'h002, 32'h0, 32'h30000, 32'h0, 32'h004};
  localparam logic TC [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] TE [NV] = '{
    32'h100, 32'h100, 32'h10100, 32'h100, 32'h10101, 32'h101, 32'h101, 32'h103,
    32'h103, 32'h101, 32'h101, 32'h103, 32'h30100, 32'h100, 32'h10101, 32'h10105};
  localparam string TR [NV] = '{
    "R2", "R4", "R5", "R10", "R3", "R10", "R2", "R4",
    "R6", "R4", "R4", "R4", "R3", "R10", "R3", "R5"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, conn = 1'b0, nonrem = 1'b0;
  logic [31:0] wdat = '0, rdat;
  logic drv_rst, drv_rsm;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  usb_port_sts_reg #(.RESET_CYC(RST_N), .RESUME_CYC(RSM_N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdat),
    .rd_data_o(rdat), .connect_i(conn), .nonremovable_i(nonrem),
    .drive_reset_o(drv_rst), .drive_resume_o(drv_rsm));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic c);
    @(negedge clk);
    wr_en = 1'b1; wdat = d; conn = c;
    @(negedge clk);
    wr_en = 1'b0; wdat = '0;
  endtask

  task automatic count_high(input bit rsm, output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if ((rsm ? drv_rsm : drv_rst) !== 1'b1) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", rdat, 32'h0);
    chk("R1", {30'h0, drv_rst, drv_rsm}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wr(TW[i], TC[i]);
      chk(TR[i], rdat, TE[i]);
    end
    // R6 resume from suspend: exact length, suspend held
    wr(32'h008, 1'b1);
    chk("R6", rdat, 32'h10105);
    count_high(1'b1, n);
    chk("R6", n, RSM_N);
    chk("R7", rdat, 32'h50103);
    wr(32'h50000, 1'b1);
    chk("R10", rdat, 32'h103);
    // R8/R9 reset from suspended, disabled port
    wr(32'h001, 1'b1);
    wr(32'h004, 1'b1);
    chk("R5", rdat, 32'h105);
    wr(32'h010, 1'b1);
    chk("R8", rdat, 32'h115);
    wr(32'h010, 1'b1);  // retrigger while busy
    count_high(1'b0, n);
    chk("R8", n, RST_N - 2);
    chk("R9", rdat, 32'h100103);
    // R8 reset cancels resume
    wr(32'h004, 1'b1);
    wr(32'h008, 1'b1);
    chk("R6", {31'h0, drv_rsm}, 32'h1);
    wr(32'h010, 1'b1);
    chk("R8", {30'h0, drv_rst, drv_rsm}, 32'h2);
    count_high(1'b0, n);
    chk("R9", rdat, 32'h100103);
    // R1 non-removable device
    rst_n = 1'b0; nonrem = 1'b1; conn = 1'b0;
    @(negedge clk);
    chk("R1", rdat, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rdat & 32'h1, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule